// File: doc/BRIEF.md
# Write-Only I2C Audio Control Register Bank

This block is an I2C target that only receives. It turns serial writes into the contents of eight 8-bit audio control registers and presents all of them at once on a parallel bus. The SCL and SDA lines are sampled by the system clock after a two-flop synchroniser. The block finds START and STOP conditions on the sampled lines. It accepts only the device address byte 0x88. The next byte is a subaddress, which selects a register index and a stepping mode. Every byte after that is a data byte.

With stepping off, every data byte in the transfer lands in the same register. With stepping on, the index advances by one after each data byte and wraps from 15 back to 0. Data bytes aimed at indices 3 and 8 to 15 are acknowledged but change nothing. Each register update raises a one-cycle strobe together with the index that was written, so that downstream logic can pick up the new setting.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bits are taken MSB first, one on each SCL rising edge.
- R2: After the byte 0x88, the block pulls SDA low during the ninth clock. It does so only during that clock, and it keeps SDA low while SCL is high.
- R3: Any other address byte, including 0x89 (read bit set), gets no acknowledge. Every later byte is then ignored and gets no acknowledge until the next START.
- R4: In the subaddress byte, bits 3..0 are the register index and bit 4 enables stepping. Bits 7..5 are ignored. The subaddress byte is always acknowledged.
- R5: With bit 4 clear, every data byte up to the STOP or the next START is written to the selected register.
- R6: With bit 4 set, the first data byte goes to the selected index and each later byte goes to the previous index plus one. The 4-bit index wraps from 15 to 0.
- R7: Data bytes for index 3 or for indices 8 to 15 are acknowledged. They change no register and raise no strobe.
- R8: Register i appears on regs_o[8*i+7:8*i]. Slot 3 always reads 0x00.
- R9: Reset values: slot0 = 0x02 (input 2, code 10 in bits 1..0), slot1 = 0x0E (gain code 1110), slot2 = 0x38 (volume mute), slot4 = 0x0F (bass flat), slot5 = 0x0E (treble +2 dB), slot6 = 0x78 and slot7 = 0x78 (both speakers muted). sda_oe_o and wr_stb_o are 0.
- R10: Each register update raises wr_stb_o for exactly one cycle, with wr_idx_o set to the written index. The new value is on regs_o in that same cycle.
- R11: A repeated START restarts the address phase. After a STOP, bytes clocked without a START are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low (acknowledge) |
| regs_o | output | 64 | All eight registers, slot i at bits 8*i+7..8*i |
| wr_stb_o | output | 1 | One-cycle pulse on a register update |
| wr_idx_o | output | 3 | Index of the register just updated |

## Verification
The hardest cases to reach from the ports are the index wrap and the ignored slots inside a single transfer. The index has to climb through 8..15, wrap to 0, and pass slot 3 without writing it, and that takes ten or more data bytes without a STOP. The bench therefore starts a stepping transfer of ten bytes from every one of the 16 indices, and a fixed-mode transfer at every index. It models each write arithmetically, then compares the order of the strobes, the value captured at each strobe, and all eight slots. Rejected addresses, a read address, bytes clocked after a STOP and a repeated START each get their own transfer.

// File: rtl/aud_ctl_pkg.sv
package aud_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_SUB  = 2'd1,
    PH_DATA = 2'd2
  } rx_phase_e;

  // Reset contents of each control slot (slot 3 is an unused hole)
  function automatic logic [7:0] slot_default(input int unsigned idx);
    logic [7:0] v;
    case (idx)
      0:       v = 8'h02;
      1:       v = 8'h0E;
      2:       v = 8'h38;
      4:       v = 8'h0F;
      5:       v = 8'h0E;
      6, 7:    v = 8'h78;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic [SYNC_STAGES-1:0] scl_pipe_d, sda_pipe_d;
  logic scl_prev_q, sda_prev_q;
  logic scl_s, sda_s;

  assign scl_pipe_d = {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
  assign sda_pipe_d = {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
  assign scl_s = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s = sda_pipe_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  // R1: conditions are seen only while SCL stays high over both samples
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_write_engine.sv
module i2c_write_engine
  import aud_ctl_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         IDX_W    = 4,
  parameter logic [7:0] DEV_ADDR = 8'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);

  localparam int CNT_W    = $clog2(DATA_W + 1);
  localparam int AUTO_BIT = IDX_W;

  rx_state_e         state_q, state_d;
  rx_phase_e         phase_q, phase_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              auto_q, auto_d;
  logic              ack_q, ack_d;
  logic              wv_q, wv_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              byte_done;

  assign byte_done = scl_fall && (bitcnt_q == CNT_W'(DATA_W));

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    idx_d    = idx_q;
    auto_d   = auto_q;
    ack_d    = ack_q;
    wv_d     = 1'b0;
    widx_d   = widx_q;
    wdat_d   = wdat_q;
    if (start_det) begin
      state_d  = ST_RX;
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      ack_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      ack_d   = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && (bitcnt_q < CNT_W'(DATA_W))) begin
            shreg_d  = {shreg_q[DATA_W-2:0], sda_lvl};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (byte_done) begin
            case (phase_q)
              PH_ADDR: begin
                if (shreg_q == DATA_W'(DEV_ADDR)) begin
                  ack_d   = 1'b1;
                  state_d = ST_ACK;
                  phase_d = PH_SUB;
                end else begin
                  state_d = ST_SKIP;
                end
              end
              PH_SUB: begin
                idx_d   = shreg_q[IDX_W-1:0];
                auto_d  = shreg_q[AUTO_BIT];
                ack_d   = 1'b1;
                state_d = ST_ACK;
                phase_d = PH_DATA;
              end
              default: begin
                wv_d    = 1'b1;
                widx_d  = idx_q;
                wdat_d  = shreg_q;
                if (auto_q) idx_d = idx_q + 1'b1;
                ack_d   = 1'b1;
                state_d = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            ack_d    = 1'b0;
            bitcnt_d = '0;
            state_d  = ST_RX;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      idx_q    <= '0;
      auto_q   <= 1'b0;
      ack_q    <= 1'b0;
      wv_q     <= 1'b0;
      widx_q   <= '0;
      wdat_q   <= '0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      idx_q    <= idx_d;
      auto_q   <= auto_d;
      ack_q    <= ack_d;
      wv_q     <= wv_d;
      widx_q   <= widx_d;
      wdat_q   <= wdat_d;
    end
  end

  assign sda_oe   = ack_q;
  assign wr_valid = wv_q;
  assign wr_idx   = widx_q;
  assign wr_data  = wdat_q;

  // R2: the acknowledge starts only right after an SCL falling edge
  a_r2_ack_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R2: the acknowledge is held across the SCL rising edge of the ninth clock
  a_r2_ack_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && scl_rise) |=> sda_oe);

  // R10: a data write request is a single-cycle event
  a_r10_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R6: consecutive stepping writes land on consecutive indices
  a_r6_step_index: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && auto_q && $past(wr_valid && auto_q, 1) == 1'b0 && !start_det)
      |-> (idx_q == wr_idx + 1'b1));

endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import aud_ctl_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4,
  parameter int HOLE_IDX = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic                       stb,
  output logic [$clog2(NUM_REGS)-1:0] stb_idx
);

  localparam int SEL_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] slot_q [NUM_REGS];
  logic              write_ok;
  logic              stb_q;
  logic [SEL_W-1:0]  stb_idx_q;

  // R7: the hole and out-of-range indices never reach storage
  assign write_ok = wr_valid && (wr_idx < IDX_W'(NUM_REGS)) &&
                    (wr_idx != IDX_W'(HOLE_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) slot_q[i] <= DATA_W'(slot_default(i));
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (write_ok && (wr_idx == IDX_W'(i))) slot_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q     <= 1'b0;
      stb_idx_q <= '0;
    end else begin
      stb_q <= write_ok;
      if (write_ok) stb_idx_q <= wr_idx[SEL_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = slot_q[g];
  end

  assign stb     = stb_q;
  assign stb_idx = stb_idx_q;

  // R7: a strobe never names the hole
  a_r7_no_hole_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (stb_idx != SEL_W'(HOLE_IDX)));

  // R10: register contents move only together with a strobe
  a_r10_change_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_flat) |-> stb);

  // R8: the hole slot keeps reading zero
  a_r8_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[HOLE_IDX*DATA_W +: DATA_W] == '0);

endmodule

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave #(
  parameter int         NUM_REGS    = 8,
  parameter int         DATA_W      = 8,
  parameter int         IDX_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = 8'h88
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe_o,
  output logic [NUM_REGS*DATA_W-1:0]  regs_o,
  output logic                        wr_stb_o,
  output logic [$clog2(NUM_REGS)-1:0] wr_idx_o
);

  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_valid;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_write_engine #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  ctl_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .regs_flat (regs_o),
    .stb       (wr_stb_o),
    .stb_idx   (wr_idx_o)
  );

endmodule

// File: tb/test_audio_ctl_i2c_slave.sv
`timescale 1ns/1ps
module test_audio_ctl_i2c_slave;

  localparam int Q = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [63:0] regs;
  logic        wr_stb;
  logic [2:0]  wr_idx;
  logic        sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  audio_ctl_i2c_slave i_audio_ctl_i2c_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .regs_o   (regs),
    .wr_stb_o (wr_stb),
    .wr_idx_o (wr_idx)
  );

  int vecs = 0;
  int errs = 0;
  int cyc  = 0;
  logic [7:0] model [8];
  int exp_idx [256];
  int exp_val [256];
  int exp_n = 0;
  int obs_idx [256];
  int obs_val [256];
  int obs_n = 0;
  logic prev_stb = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // strobe monitor (R10)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (wr_stb) begin
        if (obs_n < 256) begin
          obs_idx[obs_n] = int'(wr_idx);
          obs_val[obs_n] = int'(regs[wr_idx*8 +: 8]);
        end
        obs_n++;
        chk(!prev_stb, "R10 strobe width", 2, 1);
      end
      prev_stb = wr_stb;
    end
    if (cyc > 190000) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq(Q);
      scl_m = 1'b1; waitq(2*Q);
      scl_m = 1'b0; waitq(Q);
    end
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    acked = !sda_line;
    waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string req);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  task automatic model_write(inout int idx, input logic [7:0] b, input bit step);
    if (idx < 8 && idx != 3) begin
      model[idx] = b;
      exp_idx[exp_n] = idx;
      exp_val[exp_n] = int'(b);
      exp_n++;
    end
    if (step) idx = (idx + 1) % 16;
  endtask

  task automatic check_all(input string req);
    chk(obs_n == exp_n, {req, " strobe count"}, obs_n, exp_n);
    for (int k = 0; k < exp_n && k < obs_n; k++) begin
      chk(obs_idx[k] == exp_idx[k], {req, " strobe index"}, obs_idx[k], exp_idx[k]);
      chk(obs_val[k] == exp_val[k], {req, " value at strobe"}, obs_val[k], exp_val[k]);
    end
    for (int s = 0; s < 8; s++)
      chk(regs[s*8 +: 8] == model[s], {req, " R8 slot"}, int'(regs[s*8 +: 8]), int'(model[s]));
    chk(sda_oe == 1'b0, {req, " R2 released"}, int'(sda_oe), 0);
    obs_n = 0;
    exp_n = 0;
  endtask

  // one complete write transfer, modelled byte by byte
  task automatic transfer(input logic [7:0] sub, input int n, input int seed, input string req);
    int idx;
    bit step;
    idx  = int'(sub[3:0]);
    step = sub[4];
    bus_start();
    send_chk(8'h88, 1'b1, "R2 address ack");
    send_chk(sub, 1'b1, "R4 subaddress ack");
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = 8'((seed * 37 + k * 11 + 5) & 255);
      send_chk(b, 1'b1, "R7 data ack");
      model_write(idx, b, step);
    end
    bus_stop();
    waitq(4);
    check_all(req);
  endtask

  initial begin
    for (int s = 0; s < 8; s++) model[s] = 8'h00;
    model[0] = 8'h02; model[1] = 8'h0E; model[2] = 8'h38;
    model[4] = 8'h0F; model[5] = 8'h0E; model[6] = 8'h78; model[7] = 8'h78;
    waitq(5);
    rst_n = 1'b1;
    waitq(5);
    chk(wr_stb == 1'b0, "R9 reset strobe", int'(wr_stb), 0);
    check_all("R9 reset defaults");

    // R5: fixed-index writes at every index, bits 7..5 set on odd indices (R4)
    for (int i = 0; i < 16; i++) begin
      logic [7:0] sub;
      sub = 8'(i) | ((i % 2 == 1) ? 8'hE0 : 8'h00);
      transfer(sub, 3, i, "R5 fixed index");
    end

    // R6: stepping transfers from every start index, crossing the wrap
    for (int i = 0; i < 16; i++)
      transfer(8'h10 | 8'(i), 10, i + 40, "R6 stepping wrap");

    // R3: wrong address, then the read address
    bus_start();
    send_chk(8'h8A, 1'b0, "R3 wrong address nack");
    send_chk(8'h00, 1'b0, "R3 ignored byte");
    send_chk(8'h55, 1'b0, "R3 ignored byte");
    bus_stop();
    waitq(4);
    check_all("R3 wrong address");
    bus_start();
    send_chk(8'h89, 1'b0, "R3 read address nack");
    send_chk(8'h01, 1'b0, "R3 ignored byte");
    send_chk(8'hA5, 1'b0, "R3 ignored byte");
    bus_stop();
    waitq(4);
    check_all("R3 read address");

    // R11: bytes after a STOP without a new START
    send_chk(8'h88, 1'b0, "R11 no start nack");
    send_chk(8'h02, 1'b0, "R11 no start nack");
    send_chk(8'h11, 1'b0, "R11 no start nack");
    waitq(4);
    check_all("R11 after stop");

    // R11: repeated START restarts the address phase
    begin
      int idx;
      bus_start();
      send_chk(8'h88, 1'b1, "R11 first address");
      send_chk(8'h00, 1'b1, "R11 first sub");
      send_chk(8'h03, 1'b1, "R11 first data");
      idx = 0; model_write(idx, 8'h03, 1'b0);
      bus_start();
      send_chk(8'h88, 1'b1, "R11 restart address");
      send_chk(8'h01, 1'b1, "R11 restart sub");
      send_chk(8'h4C, 1'b1, "R11 restart data");
      idx = 1; model_write(idx, 8'h4C, 1'b0);
      bus_start();
      send_chk(8'h8A, 1'b0, "R11 restart bad address");
      send_chk(8'hFF, 1'b0, "R11 restart ignored");
      bus_stop();
      waitq(4);
      check_all("R11 repeated start");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule